// File: doc/BRIEF.md
# Hamming (31,26) Even-Parity Codec

This block protects a 26-bit data word with a single-error-correcting Hamming code. The encoder side takes one data word per cycle, tagged by a valid strobe, and returns the 31-bit codeword one clock later. Five check bits are added at the power-of-two positions, and each check bit makes its group even.

The checker side takes a received 31-bit word, also with a valid strobe. It recomputes the five parity groups into a syndrome. If the syndrome is nonzero, it inverts the bit that the syndrome points at. It then gathers the 26 data bits back out and presents them, the syndrome and a correction flag one clock later.

Both paths are pure pipelines: one register stage each, no back-pressure, and a new word accepted on every cycle.

Top module: `ham31_codec`

## Requirements
- R1: Codeword positions are numbered from 1, where position p is code bit p-1. Check bits sit at positions 1, 2, 4, 8 and 16 (code bits 0, 1, 3, 7, 15). Data bit 0 goes to the lowest remaining position (3), and the remaining data bits fill the other positions in ascending order, so data bit 25 lands at position 31.
- R2: Check bit k (k = 0..4, at position 2^k) is set so that the XOR of all positions whose index has bit k set, itself included, is 0.
- R3: Data word 0x0000444 encodes to codeword 0x00004422.
- R4: On each clock where data_valid_i is high, code_o shows that word's codeword after exactly one clock and code_valid_o is high for that cycle. Otherwise code_valid_o is low and code_o keeps its last value.
- R5: While rst_ni is low, all outputs are 0.
- R6: rx_syndrome_o is 0 for a valid codeword. For a codeword with exactly one bit flipped at position p, it equals p. It appears one clock after rx_valid_i.
- R7: When a valid codeword has any single bit flipped, check bits included, rx_data_o returns the original 26-bit data and err_fixed_o is high for that word.
- R8: For an error-free codeword, rx_data_o returns the data and err_fixed_o stays low.
- R9: rx_valid_o is high exactly one clock after each cycle in which rx_valid_i is high. err_fixed_o is never high without rx_valid_o. When rx_valid_i is low, rx_data_o and rx_syndrome_o keep their last values.
- R10: Both paths accept a new word on every consecutive clock, and each result lines up with its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 26 | Data word to encode |
| data_valid_i | input | 1 | data_i is valid this cycle |
| code_o | output | 31 | Encoded codeword |
| code_valid_o | output | 1 | code_o holds a fresh codeword |
| rx_code_i | input | 31 | Received codeword to check |
| rx_valid_i | input | 1 | rx_code_i is valid this cycle |
| rx_data_o | output | 26 | Corrected, extracted data |
| rx_syndrome_o | output | 5 | Syndrome: 0 when clean, otherwise the flipped position |
| rx_valid_o | output | 1 | Checker outputs are fresh |
| err_fixed_o | output | 1 | A single-bit error was corrected in this word |

## Verification
A wrong position map or a wrong group mask shows up in the very next codeword. It breaks the 0x444 known answer or the even-parity property, so it is visible on code_o one clock after the word goes in. In the checker, a misrouted syndrome bit or extraction tap only shows when the syndrome is nonzero or when a specific data bit is set. For that reason every one of the 31 single-bit flips, and data patterns that walk each bit, are run through the checker, with results compared one clock after each input. Holding valid low while changing the inputs shows whether the output registers load when they should not.

// File: rtl/ham_pkg.sv
package ham_pkg;
  localparam int unsigned MAX_W = 64;

  // Positions (1-based) covered by check group k
  function automatic logic [MAX_W-1:0] group_mask(input int unsigned k, input int unsigned code_w);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int unsigned p = 1; p <= code_w; p++)
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

  // 1-based position of data bit idx; data fills non-power-of-two slots ascending
  function automatic int unsigned data_pos(input int unsigned idx, input int unsigned code_w);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 1; p <= code_w; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ham_encode.sv
module ham_encode #(
  parameter int unsigned PAR_W = 5,
  localparam int unsigned CODE_W = (1 << PAR_W) - 1,
  localparam int unsigned DATA_W = CODE_W - PAR_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] spread;

  for (genvar i = 0; i < DATA_W; i++) begin : g_scatter
    localparam int unsigned POS = ham_pkg::data_pos(i, CODE_W);
    assign spread[POS-1] = data_i[i];
  end

  for (genvar b = 0; b < CODE_W; b++) begin : g_out
    if (((b + 1) & b) == 0) begin : g_par
      localparam int unsigned K = $clog2(b + 1);
      localparam logic [CODE_W-1:0] MASK = CODE_W'(ham_pkg::group_mask(K, CODE_W));
      assign spread[b] = 1'b0;
      assign code_o[b] = ^(spread & MASK);
    end else begin : g_dat
      assign code_o[b] = spread[b];
    end
  end
endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome #(
  parameter int unsigned PAR_W = 5,
  localparam int unsigned CODE_W = (1 << PAR_W) - 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [PAR_W-1:0]  syn_o
);
  for (genvar k = 0; k < PAR_W; k++) begin : g_grp
    localparam logic [CODE_W-1:0] MASK = CODE_W'(ham_pkg::group_mask(k, CODE_W));
    assign syn_o[k] = ^(code_i & MASK);
  end
endmodule

// File: rtl/ham_enc_stage.sv
module ham_enc_stage #(
  parameter int unsigned PAR_W = 5,
  localparam int unsigned CODE_W = (1 << PAR_W) - 1,
  localparam int unsigned DATA_W = CODE_W - PAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  logic [CODE_W-1:0] code_d;

  ham_encode #(.PAR_W(PAR_W)) u_encode (.data_i(data_i), .code_o(code_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end

  // Registered codeword must satisfy every group
  logic [PAR_W-1:0] out_syn;
  ham_syndrome #(.PAR_W(PAR_W)) u_out_syn (.code_i(code_o), .syn_o(out_syn));

  p_code_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> out_syn == '0);
  p_enc_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> valid_o == $past(valid_i));
  p_enc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o));
endmodule

// File: rtl/ham_chk_stage.sv
module ham_chk_stage #(
  parameter int unsigned PAR_W = 5,
  localparam int unsigned CODE_W = (1 << PAR_W) - 1,
  localparam int unsigned DATA_W = CODE_W - PAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              valid_i,
  output logic [DATA_W-1:0] data_o,
  output logic [PAR_W-1:0]  syn_o,
  output logic              valid_o,
  output logic              fixed_o
);
  logic [PAR_W-1:0]  syn_d;
  logic [CODE_W-1:0] flip;
  logic [CODE_W-1:0] fixed_code;
  logic [DATA_W-1:0] data_d;

  ham_syndrome #(.PAR_W(PAR_W)) u_syn (.code_i(code_i), .syn_o(syn_d));

  // Nonzero syndrome is the 1-based position to invert
  assign flip       = (syn_d != '0) ? (CODE_W'(1) << (syn_d - PAR_W'(1))) : '0;
  assign fixed_code = code_i ^ flip;

  for (genvar i = 0; i < DATA_W; i++) begin : g_gather
    localparam int unsigned POS = ham_pkg::data_pos(i, CODE_W);
    assign data_d[i] = fixed_code[POS-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      syn_o   <= '0;
      valid_o <= 1'b0;
      fixed_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      fixed_o <= valid_i && (syn_d != '0);
      if (valid_i) begin
        data_o <= data_d;
        syn_o  <= syn_d;
      end
    end
  end

  p_chk_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> valid_o == $past(valid_i));
  p_fix_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_o |-> valid_o);
  p_fix_one_hot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flip));
  p_chk_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o) && $stable(syn_o));
endmodule

// File: rtl/ham31_codec.sv
module ham31_codec #(
  parameter int unsigned PAR_W = 5,
  localparam int unsigned CODE_W = (1 << PAR_W) - 1,
  localparam int unsigned DATA_W = CODE_W - PAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_valid_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  input  logic [CODE_W-1:0] rx_code_i,
  input  logic              rx_valid_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [PAR_W-1:0]  rx_syndrome_o,
  output logic              rx_valid_o,
  output logic              err_fixed_o
);
  ham_enc_stage #(.PAR_W(PAR_W)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(data_valid_i),
    .code_o (code_o),
    .valid_o(code_valid_o)
  );

  ham_chk_stage #(.PAR_W(PAR_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (rx_code_i),
    .valid_i(rx_valid_i),
    .data_o (rx_data_o),
    .syn_o  (rx_syndrome_o),
    .valid_o(rx_valid_o),
    .fixed_o(err_fixed_o)
  );

  p_reset_quiet_r5: assert property (@(posedge clk_i)
    !rst_ni |-> !code_valid_o && !rx_valid_o && !err_fixed_o);
endmodule

// File: tb/ham31_codec_bench.sv
module ham31_codec_bench;
  localparam int CW = 31;
  localparam int DW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          data_vld = 1'b0;
  logic [CW-1:0] code;
  logic          code_vld;
  logic [CW-1:0] rx_code = '0;
  logic          rx_vld = 1'b0;
  logic [DW-1:0] rx_data;
  logic [4:0]    rx_syn;
  logic          rx_vld_o;
  logic          err_fix;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ham31_codec u_ham31_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .data_i(data_in), .data_valid_i(data_vld),
    .code_o(code), .code_valid_o(code_vld),
    .rx_code_i(rx_code), .rx_valid_i(rx_vld),
    .rx_data_o(rx_data), .rx_syndrome_o(rx_syn),
    .rx_valid_o(rx_vld_o), .err_fixed_o(err_fix)
  );

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Reference encoder built from R1 and R2
  function automatic logic [CW-1:0] ref_enc(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= CW; p++)
      if (!is_pow2(p)) begin c[p-1] = d[j]; j++; end
    for (int k = 0; k < 5; k++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (p[k]) x ^= c[p-1];
      c[(1 << k) - 1] = x;
    end
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enc_step(logic [DW-1:0] d, string req);
    @(negedge clk);
    data_in  = d;
    data_vld = 1'b1;
    @(posedge clk); #1;
    check({req, " code"}, 64'(code), 64'(ref_enc(d)));
    check({req, " code_valid"}, 64'(code_vld), 64'd1);
  endtask

  task automatic chk_step(logic [CW-1:0] c, logic [DW-1:0] exp_d, logic [4:0] exp_syn, string req);
    @(negedge clk);
    rx_code = c;
    rx_vld  = 1'b1;
    @(posedge clk); #1;
    check({req, " data"}, 64'(rx_data), 64'(exp_d));
    check({req, " syndrome"}, 64'(rx_syn), 64'(exp_syn));
    check({req, " err_fixed"}, 64'(err_fix), 64'(exp_syn != 0));
    check({req, " rx_valid"}, 64'(rx_vld_o), 64'd1);
  endtask

  task automatic idle();
    @(negedge clk);
    data_vld = 1'b0;
    rx_vld   = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R5 code_valid", 64'(code_vld), 64'd0);
    check("R5 code", 64'(code), 64'd0);
    check("R5 rx_valid", 64'(rx_vld_o), 64'd0);
    check("R5 err_fixed", 64'(err_fix), 64'd0);
    check("R5 rx_data", 64'(rx_data), 64'd0);
  endtask

  task automatic t_known();
    @(negedge clk);
    data_in = 26'h444;
    data_vld = 1'b1;
    @(posedge clk); #1;
    check("R3 known answer", 64'(code), 64'h4422);
    idle();
  endtask

  task automatic t_layout();
    // R1: walk each data bit to its expected position
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] d;
      d = '0;
      d[i] = 1'b1;
      @(negedge clk);
      data_in = d;
      data_vld = 1'b1;
      @(posedge clk); #1;
      check("R1 data position", 64'(code & ~31'h0000808B), 64'(ref_enc(d) & ~31'h0000808B));
    end
    idle();
  endtask

  task automatic t_patterns();
    enc_step(26'h3FFFFFF, "R2 all ones");
    enc_step(26'h2AAAAAA, "R2 alternating");
    enc_step(26'h1555555, "R2 alternating inv");
    enc_step(26'h0000001, "R2 lsb");
    enc_step(26'h2000000, "R2 msb");
    idle();
  endtask

  task automatic t_hold();
    enc_step(26'h0123456, "R4 load");
    @(negedge clk);
    data_vld = 1'b0;
    data_in  = 26'h3ABCDEF;
    @(posedge clk); #1;
    check("R4 valid low", 64'(code_vld), 64'd0);
    check("R4 code held", 64'(code), 64'(ref_enc(26'h0123456)));
    chk_step(ref_enc(26'h0A5A5A5), 26'h0A5A5A5, 5'd0, "R9 load");
    @(negedge clk);
    rx_vld  = 1'b0;
    rx_code = 31'h7FFFFFFF;
    @(posedge clk); #1;
    check("R9 rx_valid low", 64'(rx_vld_o), 64'd0);
    check("R9 no flag", 64'(err_fix), 64'd0);
    check("R9 data held", 64'(rx_data), 64'h0A5A5A5);
    check("R9 syndrome held", 64'(rx_syn), 64'd0);
  endtask

  task automatic t_clean();
    chk_step(ref_enc(26'h0000000), 26'h0000000, 5'd0, "R8 zero");
    chk_step(ref_enc(26'h3FFFFFF), 26'h3FFFFFF, 5'd0, "R8 ones");
    chk_step(31'h4422, 26'h444, 5'd0, "R8 known");
    idle();
  endtask

  task automatic t_flips();
    logic [DW-1:0] d;
    d = 26'h2C3A5F1;
    for (int p = 1; p <= CW; p++) begin
      logic [CW-1:0] c;
      c = ref_enc(d);
      c[p-1] = ~c[p-1];
      chk_step(c, d, 5'(p), "R6 R7 single flip");
    end
    idle();
  endtask

  task automatic t_stream();
    // R10: back-to-back on both paths
    logic [DW-1:0] d;
    for (int n = 0; n < 8; n++) begin
      d = 26'(32'h01357BD * (n + 1) ^ 32'h2A0F0F0);
      @(negedge clk);
      data_in  = d;
      data_vld = 1'b1;
      rx_code  = ref_enc(d) ^ (31'd1 << (n * 3));
      rx_vld   = 1'b1;
      @(posedge clk); #1;
      check("R10 stream code", 64'(code), 64'(ref_enc(d)));
      check("R10 stream rx_data", 64'(rx_data), 64'(d));
      check("R10 stream syndrome", 64'(rx_syn), 64'(n * 3 + 1));
      check("R10 stream flag", 64'(err_fix), 64'd1);
    end
    idle();
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_known();
    t_layout();
    t_patterns();
    t_hold();
    t_clean();
    t_flips();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule